// File: doc/BRIEF.md
# Write-Protect Boundary Register Unit

This unit holds the protection state of a word-addressed non-volatile memory: a boundary address, a flag that says whether protection is cleared, and a permanent lock bit. A serial front end decodes instructions and passes protect-class commands to this unit. The unit updates its state from them and answers readback requests. A memory write engine sends a query strobe before it commits a single-word, page or whole-array write. The unit answers one cycle later with a write-allowed bit.

When the clear flag is low, every word whose address is at or above the boundary is protected. Only the low seven address bits take part in the comparison. The clear flag is active-high, so a value of 1 means no protection. Changing the boundary or clearing it is a two-step operation: an arming command must come first, and both steps need the write-enable pin and the write-enable latch. A lock command freezes the boundary and flag for good. The lock bit models a one-time-programmable cell, so it is not affected by reset.

Top module: `wprot_unit`

## Requirements
- R1: After reset the readback is 9'h1FF (clear flag 1, boundary 8'hFF), the unit is not armed, and every single-word and whole-array query made with the latch set is allowed.
- R2: The set-boundary command (op_kind 1) loads op_addr into the boundary and drives the clear flag to 0. It takes effect only when it is gated (wr_pin=1, wel=1), the unit is armed, and the unit is not locked.
- R3: A single-word query (q_kind 0) is allowed when wel=1 and either the clear flag is 1 or q_addr[6:0] is below boundary[6:0]. With wel=0 it is always refused.
- R4: A page query (q_kind 1) covers the aligned group of 2**PAGE_W words that contains q_addr (four words by default). It is allowed when wel=1 and either the flag is 1 or the highest address of that group, taken in bits [6:0], is below boundary[6:0].
- R5: A whole-array query (q_kind 2) is allowed only when wel=1 and the clear flag is 1.
- R6: The clear command (op_kind 2) sets the flag to 1 and the boundary to 8'hFF. It acts only when op_addr is 8'hFF and the command is gated, armed and not locked. With any other address it changes nothing.
- R7: Arm (op_kind 3), set-boundary and clear have no effect unless wr_pin=1 and wel=1.
- R8: Arming lasts until one set-boundary or clear command executes, which consumes it. Set-boundary and clear are ignored when the unit is not armed. A command that is rejected does not consume the arming.
- R9: The lock command (op_kind 4) sets the lock bit only when op_addr is 8'h00, wr_pin=1 and wel=1. Once set, the lock bit stays set, including through reset.
- R10: While locked, set-boundary and clear are ignored, and the boundary and flag keep their values.
- R11: Address bit 7 plays no part in protection decisions. For example, with boundary 8'h40, address 8'hBF is allowed and address 8'hC0 is refused.
- R12: A read command (op_kind 0) returns {flag, boundary} on rd_data with a one-cycle rd_vld pulse on the next cycle. A query gives wr_ok with a one-cycle ok_vld pulse on the next cycle. Both valid outputs are 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (lock bit excluded) |
| op_valid | input | 1 | Protect command strobe |
| op_kind | input | 3 | 0 read, 1 set boundary, 2 clear, 3 arm, 4 lock |
| op_addr | input | 8 | Address field of the protect command |
| wr_pin | input | 1 | Write-enable pin level |
| wel | input | 1 | Write-enable latch state |
| q_valid | input | 1 | Write query strobe |
| q_kind | input | 2 | 0 single word, 1 page, 2 whole array |
| q_addr | input | 8 | Address targeted by the queried write |
| wr_ok | output | 1 | Write allowed, valid with ok_vld |
| ok_vld | output | 1 | Query answer pulse |
| rd_data | output | 9 | {clear flag, boundary[7:0]} |
| rd_vld | output | 1 | Readback pulse |

## Verification
The hardest state to reach is the lock state, together with the proof that it outlasts reset. The lock command needs both enables and an all-zero address, and once it is set nothing can undo it. The stimulus therefore keeps it for the last part of the run. First, the bench shows that a lock command with a nonzero address, and one with the pin low, still leave the boundary writable. Then it locks the unit and tries an armed set-boundary and an armed clear. Finally it applies reset and checks that an armed set-boundary is still refused. The arming rules are checked in the same way: rejected commands are sent both before and after a successful one, and the boundary is read back after each.

// File: rtl/wprot_pkg.sv
package wprot_pkg;

    localparam int ADDR_W = 8;
    localparam int CMP_W  = 7;
    localparam int RD_W   = ADDR_W + 1;

    typedef enum logic [2:0] {
        POP_READ  = 3'd0,
        POP_SETB  = 3'd1,
        POP_CLEAR = 3'd2,
        POP_ARM   = 3'd3,
        POP_LOCK  = 3'd4
    } pop_e;

    typedef enum logic [1:0] {
        WK_WORD = 2'd0,
        WK_PAGE = 2'd1,
        WK_ALL  = 2'd2
    } wk_e;

    typedef struct packed {
        logic              rd;
        logic              setb;
        logic              clr;
        logic              arm;
        logic              lock;
        logic [ADDR_W-1:0] addr;
    } pact_t;

    typedef struct packed {
        logic [ADDR_W-1:0] bound;
        logic              clear;
        logic              locked;
        logic              armed;
    } pstate_t;

    function automatic logic [ADDR_W-1:0] group_top(input logic [ADDR_W-1:0] a,
                                                    input int unsigned pw);
        logic [ADDR_W-1:0] m;
        m = '0;
        for (int i = 0; i < ADDR_W; i++)
            if (i < int'(pw)) m[i] = 1'b1;
        return a | m;
    endfunction

endpackage

// File: rtl/wprot_cmd_dec.sv
module wprot_cmd_dec
    import wprot_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  pop_e              op_kind,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic              wr_pin,
    input  logic              wel,
    input  pstate_t           st,
    output pact_t             act
);
    logic gate;
    logic may_alter;

    assign gate      = wr_pin & wel;
    assign may_alter = gate & st.armed & ~st.locked;

    always_comb begin
        act      = '0;
        act.addr = op_addr;
        if (op_valid) begin
            unique case (op_kind)
                POP_READ:  act.rd   = 1'b1;
                POP_SETB:  act.setb = may_alter;
                POP_CLEAR: act.clr  = may_alter & (&op_addr);
                POP_ARM:   act.arm  = gate;
                POP_LOCK:  act.lock = gate & ~(|op_addr);
                default:   act      = '0;
            endcase
        end
    end

    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (rst)
        $onehot0({act.rd, act.setb, act.clr, act.arm, act.lock})); // R7
    AST_GATED_CHANGE: assert property (@(posedge clk) disable iff (rst)
        (act.setb || act.clr || act.arm) |-> (wr_pin && wel)); // R7
    AST_LOCK_NEEDS_ZERO: assert property (@(posedge clk) disable iff (rst)
        act.lock |-> (op_addr == '0)); // R9

endmodule

// File: rtl/wprot_state.sv
module wprot_state
    import wprot_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  pact_t           act,
    output pstate_t         st,
    output logic [RD_W-1:0] rd_data,
    output logic            rd_vld
);
    logic [ADDR_W-1:0] bound_q;
    logic              clear_q;
    logic              armed_q;
    logic              lock_q = 1'b0;

    always_ff @(posedge clk) begin
        if (rst) begin
            bound_q <= '1;
            clear_q <= 1'b1;
            armed_q <= 1'b0;
        end else begin
            if (act.setb) begin
                bound_q <= act.addr;
                clear_q <= 1'b0;
                armed_q <= 1'b0;
            end else if (act.clr) begin
                bound_q <= '1;
                clear_q <= 1'b1;
                armed_q <= 1'b0;
            end else if (act.arm) begin
                armed_q <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (act.lock) lock_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
            rd_vld  <= 1'b0;
        end else begin
            rd_vld <= act.rd;
            if (act.rd) rd_data <= {clear_q, bound_q};
        end
    end

    assign st.bound  = bound_q;
    assign st.clear  = clear_q;
    assign st.locked = lock_q;
    assign st.armed  = armed_q;

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
        lock_q |=> lock_q); // R9
    AST_LOCKED_FROZEN: assert property (@(posedge clk) disable iff (rst)
        lock_q |=> ($stable(bound_q) && $stable(clear_q))); // R10
    AST_CLEAR_MEANS_TOP: assert property (@(posedge clk) disable iff (rst)
        clear_q |-> (&bound_q)); // R6
    AST_ARM_CONSUMED: assert property (@(posedge clk) disable iff (rst)
        (act.setb || act.clr) |=> !armed_q); // R8

endmodule

// File: rtl/wprot_judge.sv
module wprot_judge
    import wprot_pkg::*;
#(
    parameter int unsigned PAGE_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              q_valid,
    input  wk_e               q_kind,
    input  logic [ADDR_W-1:0] q_addr,
    input  logic              wel,
    input  pstate_t           st,
    output logic              wr_ok,
    output logic              ok_vld
);
    logic [ADDR_W-1:0] probe;
    logic              hit;
    logic              verdict;

    always_comb begin
        probe = (q_kind == WK_PAGE) ? group_top(q_addr, PAGE_W) : q_addr;
        hit   = ~st.clear & (probe[CMP_W-1:0] >= st.bound[CMP_W-1:0]);
        unique case (q_kind)
            WK_WORD, WK_PAGE: verdict = wel & ~hit;
            WK_ALL:           verdict = wel & st.clear;
            default:          verdict = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ok  <= 1'b0;
            ok_vld <= 1'b0;
        end else begin
            ok_vld <= q_valid;
            wr_ok  <= q_valid & verdict;
        end
    end

    AST_NO_LATCH_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (q_valid && !wel) |=> !wr_ok); // R3
    AST_ALL_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (q_valid && q_kind == WK_ALL && !st.clear) |=> !wr_ok); // R5
    AST_ANSWER_PULSE: assert property (@(posedge clk) disable iff (rst)
        q_valid |=> ok_vld); // R12
    AST_OK_ONLY_WITH_VLD: assert property (@(posedge clk) disable iff (rst)
        wr_ok |-> ok_vld); // R12

endmodule

// File: rtl/wprot_unit.sv
module wprot_unit
    import wprot_pkg::*;
#(
    parameter int unsigned PAGE_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [2:0]        op_kind,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic              wr_pin,
    input  logic              wel,
    input  logic              q_valid,
    input  logic [1:0]        q_kind,
    input  logic [ADDR_W-1:0] q_addr,
    output logic              wr_ok,
    output logic              ok_vld,
    output logic [RD_W-1:0]   rd_data,
    output logic              rd_vld
);
    pact_t   act;
    pstate_t st;

    wprot_cmd_dec u_dec (
        .clk      (clk),
        .rst      (rst),
        .op_valid (op_valid),
        .op_kind  (pop_e'(op_kind)),
        .op_addr  (op_addr),
        .wr_pin   (wr_pin),
        .wel      (wel),
        .st       (st),
        .act      (act)
    );

    wprot_state u_state (
        .clk     (clk),
        .rst     (rst),
        .act     (act),
        .st      (st),
        .rd_data (rd_data),
        .rd_vld  (rd_vld)
    );

    wprot_judge #(.PAGE_W(PAGE_W)) u_judge (
        .clk     (clk),
        .rst     (rst),
        .q_valid (q_valid),
        .q_kind  (wk_e'(q_kind)),
        .q_addr  (q_addr),
        .wel     (wel),
        .st      (st),
        .wr_ok   (wr_ok),
        .ok_vld  (ok_vld)
    );

    AST_RD_PULSE: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_kind == 3'd0) |=> rd_vld); // R12

endmodule

// File: tb/wprot_unit_test.sv
module wprot_unit_test;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 56;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       op_valid = 1'b0;
    logic [2:0] op_kind = '0;
    logic [7:0] op_addr = '0;
    logic       wr_pin = 1'b0;
    logic       wel = 1'b0;
    logic       q_valid = 1'b0;
    logic [1:0] q_kind = '0;
    logic [7:0] q_addr = '0;
    logic       wr_ok, ok_vld, rd_vld;
    logic [8:0] rd_data;

    int applied = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wprot_unit uut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(op_kind),
        .op_addr(op_addr), .wr_pin(wr_pin), .wel(wel), .q_valid(q_valid),
        .q_kind(q_kind), .q_addr(q_addr), .wr_ok(wr_ok), .ok_vld(ok_vld),
        .rd_data(rd_data), .rd_vld(rd_vld)
    );

    // vector: [31:28] req, [27:26] type (0 op, 1 query, 2 read),
    // [25:23] kind, [22:15] addr, [14] pin, [13] wel, [8:0] expected
    function automatic logic [31:0] opv(int r, int k, int a, int p, int w);
        return {4'(r), 2'd0, 3'(k), 8'(a), 1'(p), 1'(w), 4'd0, 9'd0};
    endfunction
    function automatic logic [31:0] qv(int r, int k, int a, int e);
        return {4'(r), 2'd1, 3'(k), 8'(a), 1'b0, 1'b1, 4'd0, 9'(e)};
    endfunction
    function automatic logic [31:0] rv(int r, int e);
        return {4'(r), 2'd2, 3'd0, 8'd0, 1'b0, 1'b0, 4'd0, 9'(e)};
    endfunction

    localparam logic [31:0] VEC [NV] = '{
        rv(1, 'h1FF),           // R1 reset readback
        qv(1, 0, 'h7F, 1),      // R1 word allowed
        qv(5, 2, 'h00, 1),      // R5 all allowed while clear
        {4'd3, 2'd1, 3'd0, 8'h10, 1'b0, 1'b0, 4'd0, 9'd0}, // R3 wel low refused
        opv(8, 1, 'h40, 1, 1),  // R8 unarmed set ignored
        rv(8, 'h1FF),
        opv(7, 3, 'h00, 0, 1),  // R7 arm with pin low
        opv(7, 1, 'h40, 1, 1),
        rv(7, 'h1FF),
        opv(7, 3, 'h00, 1, 0),  // R7 arm with wel low
        opv(7, 1, 'h40, 1, 1),
        rv(7, 'h1FF),
        opv(2, 3, 'h00, 1, 1),  // R2 arm
        opv(7, 1, 'h40, 0, 1),  // R7 set with pin low, keeps arming
        rv(7, 'h1FF),
        opv(2, 1, 'h40, 1, 1),  // R2 set boundary
        rv(2, 'h040),
        qv(3, 0, 'h3F, 1),      // R3
        qv(3, 0, 'h40, 0),
        qv(11, 0, 'hBF, 1),     // R11
        qv(11, 0, 'hC0, 0),
        qv(4, 1, 'h3C, 1),      // R4
        qv(4, 1, 'h3D, 1),
        qv(4, 1, 'h40, 0),
        qv(5, 2, 'h00, 0),      // R5 refused while protected
        opv(8, 1, 'h3E, 1, 1),  // R8 arming consumed
        rv(8, 'h040),
        opv(2, 3, 'h00, 1, 1),
        opv(2, 1, 'h3E, 1, 1),
        rv(2, 'h03E),
        qv(4, 1, 'h3C, 0),      // R4 top of group hits
        qv(3, 0, 'h3D, 1),
        qv(4, 1, 'h38, 1),
        opv(6, 3, 'h00, 1, 1),
        opv(6, 2, 'h7F, 1, 1),  // R6 wrong clear address
        rv(6, 'h03E),
        opv(6, 2, 'hFF, 1, 1),  // R6 clear, arming kept by reject
        rv(6, 'h1FF),
        qv(5, 2, 'h00, 1),
        qv(6, 0, 'hFF, 1),
        opv(9, 4, 'h01, 1, 1),  // R9 lock with nonzero addr ignored
        opv(9, 3, 'h00, 1, 1),
        opv(9, 1, 'h20, 1, 1),
        rv(9, 'h020),
        opv(9, 4, 'h00, 0, 1),  // R9 lock with pin low ignored
        opv(9, 3, 'h00, 1, 1),
        opv(9, 1, 'h30, 1, 1),
        rv(9, 'h030),
        opv(9, 4, 'h00, 1, 1),  // R9 lock
        opv(10, 3, 'h00, 1, 1),
        opv(10, 2, 'hFF, 1, 1), // R10 clear ignored
        rv(10, 'h030),
        opv(10, 1, 'h10, 1, 1), // R10 set ignored
        rv(10, 'h030),
        qv(10, 0, 'h2F, 1),
        qv(10, 0, 'h30, 0)
    };

    task automatic idle();
        op_valid = 1'b0; q_valid = 1'b0;
    endtask

    task automatic check(int r, string what, int act, int exp);
        applied++;
        if (act != exp) begin
            bad++;
            $display("FAIL R%0d %s: got %0h expected %0h", r, what, act, exp);
        end
    endtask

    task automatic run_vec(logic [31:0] v);
        int r = int'(v[31:28]);
        idle();
        wr_pin = v[14];
        wel    = v[13];
        case (v[27:26])
            2'd0: begin op_valid = 1'b1; op_kind = v[25:23]; op_addr = v[22:15]; end
            2'd1: begin q_valid = 1'b1; q_kind = v[24:23]; q_addr = v[22:15]; end
            default: begin op_valid = 1'b1; op_kind = 3'd0; op_addr = '0; end
        endcase
        @(negedge clk);
        case (v[27:26])
            2'd0: check(12, "no pulse after command", {ok_vld, rd_vld}, 0); // R12
            2'd1: check(r, "query answer", {ok_vld, rd_vld, wr_ok}, {2'b10, v[0]});
            default: check(r, "readback", {rd_vld, ok_vld, rd_data}, {2'b10, v[8:0]});
        endcase
        idle();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        $display("FAIL R12 watchdog expired: got 0 expected 1");
        $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(1, "valids after reset", {ok_vld, rd_vld}, 0); // R1
        for (int i = 0; i < NV; i++) run_vec(VEC[i]);

        @(negedge clk);
        check(12, "idle cycle no pulses", {ok_vld, rd_vld}, 0); // R12

        // lock survives reset (R9), state itself returns to cleared (R1)
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        run_vec(rv(1, 'h1FF));
        run_vec(qv(1, 2, 'h00, 1));
        run_vec(opv(9, 3, 'h00, 1, 1));
        run_vec(opv(9, 1, 'h10, 1, 1));
        run_vec(rv(9, 'h1FF));      // R9 still locked after reset

        $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
        $finish;
    end

endmodule